// File: doc/BRIEF.md
# Timestamp-Ordered Conflict Resolver

This block referees data conflicts among a small group of hardware threads. Each thread runs an optimistic critical section and reports its memory accesses: a valid strobe, a read/write flag and a block address. When a thread enters a section that it does not already hold, the block assigns it a timestamp that no other live thread holds. The thread keeps that timestamp through every re-execution and gives it up only when it commits. The block keeps, for each thread, small tables of the blocks the thread has read and the blocks it has written. A new access is checked against the tables of the other live threads and against the accesses the other threads make in the same cycle.

Two threads conflict when they touch the same block and at least one of them writes it. The older timestamp wins. The younger side gets a one-cycle restart pulse, and its tables are emptied on the same edge. A younger thread loses whether it made the new request or was holding the block in its tables. Because a restarted thread keeps its first timestamp, it becomes older than every thread that enters later, so it wins in the end. Threads that touch disjoint blocks, or only read shared blocks, run side by side and never see a restart.

Top module: `tsr_resolver_top`

## Requirements
- R1: After reset, `restart_o` and `active_o` are all zero. The first timestamp handed out equals the parameter `STAMP_SEED`.
- R2: An `enter_i` bit for a thread whose `active_o` bit is low does three things. It sets `active_o` on the next edge. It loads the next counter value into that thread's `stamp_o` field, which is bits [t*16 +: 16]. It advances the counter. Threads entering in the same cycle get consecutive values, with lower thread indices first. Live threads never share a timestamp.
- R3: An `enter_i` bit for a thread that is already active changes neither its timestamp nor the counter.
- R4: Two accesses to the same block conflict only if at least one is a write. Reads of a shared block never cause a restart.
- R5: For an access presented in cycle n, every thread that loses a conflict sees its `restart_o` bit high in cycle n+1 for that cycle. The loser is the thread whose timestamp is later, whether it is the requester or a holder of the block.
- R6: A restart empties the loser's read and write tables. It keeps the loser's `active_o` bit and its timestamp.
- R7: When several threads collide on one block in one cycle, the thread with the earliest timestamp wins. All the threads that conflict with it are restarted together.
- R8: Timestamps are ordered by a 16-bit wrap-safe signed difference, so 16'hFFFE comes before 16'h0000.
- R9: A `commit_i` bit clears the thread's `active_o` bit and empties its tables. The next entry of that thread gets a fresh timestamp.
- R10: Accesses from a thread whose `active_o` bit is low are ignored. They restart nobody and are not recorded.
- R11: Threads whose accesses touch different blocks proceed with no restart.
- R12: The winner of a conflict records its access, so the block stays held against later, younger threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_i | input | NTHR | Per-thread section entry strobe |
| commit_i | input | NTHR | Per-thread section commit strobe |
| acc_vld_i | input | NTHR | Per-thread access valid |
| acc_wr_i | input | NTHR | Per-thread access is a write (1) or a read (0) |
| acc_addr_i | input | NTHR*12 | Per-thread block address, thread t at [t*12 +: 12] |
| restart_o | output | NTHR | One-cycle restart pulse per losing thread |
| active_o | output | NTHR | Thread holds a live timestamp |
| stamp_o | output | NTHR*16 | Per-thread timestamp, thread t at [t*16 +: 16] |

## Verification
The checker enforces four rules on every cycle. Live threads hold distinct timestamps. A live thread's timestamp never changes while it stays live. A restart lands only on a thread that is still live. At least one thread survives any round of restarts. Everything that depends on address matching needs the bench scenarios. These cover read-read sharing, a younger holder wounded by an older requester, a three-way same-cycle collision, ordering across counter wrap, tables emptied by restart and by commit, and accesses from idle threads being ignored. The bench predicts each restart vector from the timestamps and the addresses it has applied.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int unsigned STAMP_W = 16;
    localparam int unsigned ADDR_W  = 12;

    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [ADDR_W-1:0]  blk_addr_t;

    typedef enum logic {SET_READ = 1'b0, SET_WRITE = 1'b1} set_kind_e;

    typedef struct packed {
        logic      vld;
        logic      wr;
        blk_addr_t addr;
    } access_t;

    // Returns 1 when stamp a (thread ia) is ordered before stamp b (thread ib).
    // The signed difference survives counter rollover.
    function automatic logic stamp_before(input stamp_t a, input int unsigned ia,
                                          input stamp_t b, input int unsigned ib);
        stamp_t diff;
        diff = a - b;
        if (diff == '0) return (ia < ib);
        return diff[STAMP_W-1];
    endfunction
endpackage

// File: rtl/tsr_stamp_alloc.sv
module tsr_stamp_alloc
    import tsr_pkg::*;
#(
    parameter int unsigned NTHR = 4,
    parameter stamp_t      SEED = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NTHR-1:0]     enter_i,
    input  logic [NTHR-1:0]     commit_i,
    output logic [NTHR-1:0]     active_o,
    output stamp_t              stamp_o [NTHR]
);
    stamp_t          next_q;
    stamp_t          grant_stamp [NTHR];
    logic [NTHR-1:0] fresh;
    stamp_t          taken;

    always_comb begin
        taken = '0;
        for (int t = 0; t < NTHR; t++) begin
            fresh[t]       = enter_i[t] && !active_o[t] && !commit_i[t];
            grant_stamp[t] = next_q + taken;
            if (fresh[t]) taken = taken + stamp_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q   <= SEED;
            active_o <= '0;
            for (int t = 0; t < NTHR; t++) stamp_o[t] <= '0;
        end else begin
            next_q <= next_q + taken;
            for (int t = 0; t < NTHR; t++) begin
                if (commit_i[t]) begin
                    active_o[t] <= 1'b0;
                end else if (fresh[t]) begin
                    active_o[t] <= 1'b1;
                    stamp_o[t]  <= grant_stamp[t];
                end
            end
        end
    end
endmodule

// File: rtl/tsr_addr_cam.sv
module tsr_addr_cam
    import tsr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NQ    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             ins_i,
    input  blk_addr_t        ins_addr_i,
    input  blk_addr_t        q_addr_i [NQ],
    output logic [NQ-1:0]    hit_o
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] slot_vld;
    blk_addr_t        slot_addr [DEPTH];
    logic             present;
    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        present   = 1'b0;
        have_free = 1'b0;
        free_idx  = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            if (slot_vld[s] && slot_addr[s] == ins_addr_i) present = 1'b1;
            if (!slot_vld[s]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(s);
            end
        end
    end

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            hit_o[q] = 1'b0;
            for (int s = 0; s < DEPTH; s++)
                if (slot_vld[s] && slot_addr[s] == q_addr_i[q]) hit_o[q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            slot_vld <= '0;
        end else if (ins_i && !present && have_free) begin
            slot_vld[free_idx]  <= 1'b1;
            slot_addr[free_idx] <= ins_addr_i;
        end
    end
endmodule

// File: rtl/tsr_conflict_pick.sv
module tsr_conflict_pick
    import tsr_pkg::*;
#(
    parameter int unsigned NTHR = 4
) (
    input  logic [NTHR-1:0] part_i,
    input  access_t         acc_i    [NTHR],
    input  logic [NTHR-1:0] rd_hit_i [NTHR],
    input  logic [NTHR-1:0] wr_hit_i [NTHR],
    input  stamp_t          stamp_i  [NTHR],
    output logic [NTHR-1:0] lose_o
);
    // hold[t][u]: access of t collides with a table held by live thread u
    logic [NTHR-1:0] hold [NTHR];
    logic [NTHR-1:0] same [NTHR];

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            for (int u = 0; u < NTHR; u++) begin
                hold[t][u] = (t != u) && acc_i[t].vld && part_i[u] &&
                             (acc_i[t].wr ? (rd_hit_i[u][t] || wr_hit_i[u][t])
                                          : wr_hit_i[u][t]);
                same[t][u] = (t != u) && acc_i[t].vld && acc_i[u].vld &&
                             (acc_i[t].addr == acc_i[u].addr) &&
                             (acc_i[t].wr || acc_i[u].wr);
            end
        end
    end

    always_comb begin
        lose_o = '0;
        for (int t = 0; t < NTHR; t++)
            for (int u = 0; u < NTHR; u++)
                if ((hold[t][u] || hold[u][t] || same[t][u]) &&
                    stamp_before(stamp_i[u], u, stamp_i[t], t))
                    lose_o[t] = 1'b1;
    end
endmodule

// File: rtl/tsr_resolver_top.sv
module tsr_resolver_top
    import tsr_pkg::*;
#(
    parameter int unsigned NTHR       = 4,
    parameter int unsigned SET_DEPTH  = 8,
    parameter logic [15:0] STAMP_SEED = 16'h0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NTHR-1:0]          enter_i,
    input  logic [NTHR-1:0]          commit_i,
    input  logic [NTHR-1:0]          acc_vld_i,
    input  logic [NTHR-1:0]          acc_wr_i,
    input  logic [NTHR*ADDR_W-1:0]   acc_addr_i,
    output logic [NTHR-1:0]          restart_o,
    output logic [NTHR-1:0]          active_o,
    output logic [NTHR*STAMP_W-1:0]  stamp_o
);
    stamp_t          stamp_arr [NTHR];
    logic [NTHR-1:0] part;
    access_t         acc [NTHR];
    blk_addr_t       q_addr [NTHR];
    logic [NTHR-1:0] rd_hit [NTHR];
    logic [NTHR-1:0] wr_hit [NTHR];
    logic [NTHR-1:0] lose;

    assign part = active_o & ~commit_i;

    tsr_stamp_alloc #(.NTHR(NTHR), .SEED(stamp_t'(STAMP_SEED))) alloc_i (
        .clk      (clk),
        .rst      (rst),
        .enter_i  (enter_i),
        .commit_i (commit_i),
        .active_o (active_o),
        .stamp_o  (stamp_arr)
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign q_addr[t]   = acc_addr_i[t*ADDR_W +: ADDR_W];
        assign acc[t].vld  = acc_vld_i[t] && part[t];
        assign acc[t].wr   = acc_wr_i[t];
        assign acc[t].addr = q_addr[t];
        assign stamp_o[t*STAMP_W +: STAMP_W] = stamp_arr[t];

        for (genvar k = 0; k < 2; k++) begin : g_set
            localparam set_kind_e KIND = set_kind_e'(k);
            logic          ins;
            logic [NTHR-1:0] hit;
            assign ins = acc[t].vld && !lose[t] && (acc[t].wr == (KIND == SET_WRITE));

            tsr_addr_cam #(.DEPTH(SET_DEPTH), .NQ(NTHR)) cam_i (
                .clk        (clk),
                .rst        (rst),
                .clr_i      (lose[t] || commit_i[t]),
                .ins_i      (ins),
                .ins_addr_i (q_addr[t]),
                .q_addr_i   (q_addr),
                .hit_o      (hit)
            );

            if (KIND == SET_WRITE) begin : g_w
                assign wr_hit[t] = hit;
            end else begin : g_r
                assign rd_hit[t] = hit;
            end
        end
    end

    tsr_conflict_pick #(.NTHR(NTHR)) pick_i (
        .part_i   (part),
        .acc_i    (acc),
        .rd_hit_i (rd_hit),
        .wr_hit_i (wr_hit),
        .stamp_i  (stamp_arr),
        .lose_o   (lose)
    );

    always_ff @(posedge clk) begin
        if (rst) restart_o <= '0;
        else     restart_o <= lose;
    end
endmodule

// File: rtl/tsr_resolver_chk.sv
module tsr_resolver_chk #(
    parameter int unsigned NTHR = 4,
    parameter int unsigned SW   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [NTHR-1:0]     restart_o,
    input logic [NTHR-1:0]     active_o,
    input logic [NTHR*SW-1:0]  stamp_o
);
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (armed_q && $past(rst)) |-> (restart_o == '0 && active_o == '0));

    // R5
    winner_survives_chk: assert property (@(posedge clk) disable iff (rst)
        (|restart_o) |-> !(&restart_o));

    for (genvar t = 0; t < NTHR; t++) begin : g_t
        // R6
        restart_keeps_slot_chk: assert property (@(posedge clk) disable iff (rst)
            restart_o[t] |-> active_o[t]);

        // R3
        stamp_held_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(active_o[t]) && active_o[t]) |->
            (stamp_o[t*SW +: SW] == $past(stamp_o[t*SW +: SW])));

        for (genvar u = t + 1; u < NTHR; u++) begin : g_u
            // R2
            stamp_unique_chk: assert property (@(posedge clk) disable iff (rst)
                (active_o[t] && active_o[u]) |->
                (stamp_o[t*SW +: SW] != stamp_o[u*SW +: SW]));
        end
    end
endmodule

bind tsr_resolver_top tsr_resolver_chk #(.NTHR(NTHR), .SW(tsr_pkg::STAMP_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .restart_o (restart_o),
    .active_o  (active_o),
    .stamp_o   (stamp_o)
);

// File: tb/tsr_resolver_top_tb_top.sv
module tsr_resolver_top_tb_top;
    import tsr_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT-1:0] enter_i = '0, commit_i = '0, acc_vld_i = '0, acc_wr_i = '0;
    logic [NT*ADDR_W-1:0] acc_addr_i = '0;
    logic [NT-1:0] restart_o, active_o;
    logic [NT*STAMP_W-1:0] stamp_o;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    int        q_due[$];
    logic [3:0] q_exp[$];
    string     q_tag[$];

    tsr_resolver_top #(.NTHR(NT), .SET_DEPTH(8), .STAMP_SEED(16'hFFFE)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stamp_of(input int t);
        return stamp_o[t*STAMP_W +: STAMP_W];
    endfunction

    // driver: apply one cycle of stimulus and queue the predicted restart vector
    task automatic step(input logic [3:0] en, input logic [3:0] cm, input logic [3:0] v,
                        input logic [3:0] w, input blk_addr_t a0, input blk_addr_t a1,
                        input blk_addr_t a2, input blk_addr_t a3,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        enter_i = en; commit_i = cm; acc_vld_i = v; acc_wr_i = w;
        acc_addr_i = {a3, a2, a1, a0};
        q_due.push_back(cyc + 1); q_exp.push_back(exp); q_tag.push_back(tag);
    endtask

    task automatic idle();
        step(4'h0, 4'h0, 4'h0, 4'h0, '0, '0, '0, '0, 4'h0, "R11");
    endtask

    // monitor: compare restart_o against the scoreboard queue
    initial forever begin
        @(negedge clk);
        #1;
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            chk(q_tag[0], 32'(restart_o), 32'(q_exp[0]));
            void'(q_due.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 active", 32'(active_o), 0);
        chk("R1 restart", 32'(restart_o), 0);

        step(4'b0011, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R2");
        idle();
        chk("R1 seed", 32'(stamp_of(0)), 32'hFFFE);
        chk("R2 order", 32'(stamp_of(1)), 32'hFFFF);
        step(4'b0100, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R2");
        step(4'b1000, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R2");
        idle();
        chk("R2 wrap", 32'(stamp_of(2)), 32'h0000);
        chk("R2 next", 32'(stamp_of(3)), 32'h0001);
        chk("R2 active", 32'(active_o), 32'hF);

        // R4 read-read shared, R11 disjoint
        step(0, 0, 4'b0011, 4'b0000, 12'h10, 12'h10, 0, 0, 4'h0, "R4");
        step(0, 0, 4'b1100, 4'b1000, 0, 0, 12'h20, 12'h30, 4'h0, "R11");
        // R8: T2 (0000) is younger than T0/T1 (FFFE/FFFF) across the wrap
        step(0, 0, 4'b0100, 4'b0100, 0, 0, 12'h10, 0, 4'b0100, "R8");
        idle();
        chk("R6 active kept", 32'(active_o), 32'hF);
        chk("R6 stamp kept", 32'(stamp_of(2)), 32'h0000);
        step(4'b0100, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R3");
        idle();
        chk("R3 reentry", 32'(stamp_of(2)), 32'h0000);
        // R6: T2's read of 0x20 was cleared by its restart
        step(0, 0, 4'b1000, 4'b1000, 0, 0, 0, 12'h20, 4'h0, "R6");
        // R7: three-way collision on 0x40, T0 oldest
        step(0, 0, 4'b0111, 4'b0001, 12'h40, 12'h40, 12'h40, 0, 4'b0110, "R7");
        // R5: older requester wounds younger holder T3
        step(0, 0, 4'b0001, 4'b0001, 12'h30, 0, 0, 0, 4'b1000, "R5");
        // R12: winner T0 now holds 0x30
        step(0, 0, 4'b0100, 4'b0000, 0, 0, 12'h30, 0, 4'b0100, "R12");
        step(0, 4'b0010, 0, 0, 0, 0, 0, 0, 4'h0, "R9");
        idle();
        chk("R9 commit", 32'(active_o), 32'hD);
        // R10: inactive T1 writes a block held by T3
        step(0, 0, 4'b1000, 4'b0000, 0, 0, 0, 12'h50, 4'h0, "R11");
        step(0, 0, 4'b0010, 4'b0010, 0, 12'h50, 0, 0, 4'h0, "R10");
        step(4'b0010, 0, 0, 0, 0, 0, 0, 0, 4'h0, "R9");
        idle();
        chk("R9 fresh stamp (R3 no advance)", 32'(stamp_of(1)), 32'h0002);
        step(0, 4'b0001, 0, 0, 0, 0, 0, 0, 4'h0, "R9");
        idle();
        chk("R9 commit2", 32'(active_o), 32'hE);
        step(0, 0, 4'b0010, 4'b0010, 0, 12'h40, 0, 0, 4'h0, "R9");
        step(0, 0, 4'b1000, 4'b0000, 0, 0, 0, 12'h40, 4'b0010, "R5");
        idle();
        idle();
        @(negedge clk);
        #2;
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule